// File: doc/BRIEF.md
# UART Transmit Break Controller

This block sits between a UART transmit serializer and the TXD pin and produces line-break conditions on command. A start-break pulse arms it. It then waits until both the holding register and the shift register of the serializer have sent their characters. After that it drives the line low and tells the serializer to stop loading new data.

The low level lasts at least one full character time, measured in bit-period ticks. It then continues until a stop-break pulse arrives. After the break the line is forced high for a fixed idle gap so that a receiver can see where the break ends. Only then does the serializer get the line back.

The character time is worked out from the frame settings (data bits, parity, stop bits) when the low level begins. Changes to those settings during a break therefore have no effect on that break.

Top module: `uart_brk_ctrl`

## Requirements
- R1: A start-break pulse in the idle state begins a drain phase. The line stays low-forced only after `hold_full_i` and `shift_busy_i` are both low. During draining, `txd_o` follows `ser_txd_i` and `tx_pause_o` is low.
- R2: The break begins on the clock edge after the drain completes. From then until the break ends, `txd_o` is 0 and `tx_pause_o` is 1.
- R3: The low level lasts at least one character length of `bit_tick_i` pulses. A stop-break pulse that arrives before then, including during draining, is remembered and ends the break at the clock edge of the final tick of that length. With no such stop pulse, the line stays low until a stop-break pulse arrives.
- R4: The character length is 1 + D + P + S ticks. D is `data_bits_i` clamped into 5..9. P is 1 when `parity_en_i` is 1, otherwise 0. S is 2 when `two_stop_i` is 1, otherwise 1. It is captured when the break begins; later changes do not alter the current break.
- R5: After the break, `txd_o` is forced to 1 and `tx_pause_o` stays 1 for exactly 12 ticks. At the edge of the 12th tick the block returns to idle, `tx_pause_o` falls and `txd_o` follows `ser_txd_i` again.
- R6: A stop-break pulse while idle has no effect. A start-break pulse while draining, in the break or in the idle gap has no effect.
- R7: Ticks have no effect while idle, while draining, or once the minimum length has passed and the block waits for stop-break.
- R8: While `rst_n` is low and after it is released, the block is idle: `txd_o` follows `ser_txd_i` and `tx_pause_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brk_start_i | input | 1 | Start-break command pulse |
| brk_stop_i | input | 1 | Stop-break command pulse |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| data_bits_i | input | DBW (4) | Data bits per character, clamped into 5..9 |
| parity_en_i | input | 1 | A parity bit is part of each character |
| two_stop_i | input | 1 | Two stop bits instead of one |
| hold_full_i | input | 1 | Serializer holding register holds a character |
| shift_busy_i | input | 1 | Serializer shift register is sending |
| ser_txd_i | input | 1 | Serial line level from the serializer |
| txd_o | output | 1 | Line level toward the pin |
| tx_pause_o | output | 1 | Tells the serializer not to load new data |

## Verification
A state register stuck in or skipping the drain phase shows on `txd_o` within one clock of the pending flags clearing. The line is either low too early while `hold_full_i` or `shift_busy_i` is still high, or it stays high. A wrong tick count or a lost early stop moves the rising edge of `txd_o` by whole bit periods, so edge positions are compared tick by tick against the computed character length. A mistake in the gap counter shows as `tx_pause_o` falling at the wrong tick, and a mux fault shows as the serializer level leaking onto `txd_o` during the forced gap.

// File: rtl/brk_pkg.sv
package brk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_DRAIN    = 3'd1,
        ST_BRK_MIN  = 3'd2,
        ST_BRK_HOLD = 3'd3,
        ST_GAP      = 3'd4
    } brk_state_e;

    typedef struct packed {
        brk_state_e st;
        logic       stop_seen;
    } brk_fsm_regs_t;

endpackage

// File: rtl/brk_char_len.sv
module brk_char_len #(
    parameter int DBW      = 4,
    parameter int MIN_DATA = 5,
    parameter int MAX_DATA = 9,
    parameter int LW       = 4
) (
    input  logic [DBW-1:0] data_bits_i,
    input  logic           parity_en_i,
    input  logic           two_stop_i,
    output logic [LW-1:0]  char_len_o
);

    logic [LW-1:0] data_n;
    logic [LW-1:0] par_n;
    logic [LW-1:0] stop_n;

    // Clamp the data-bit count into the legal frame range.
    always_comb begin
        if (data_bits_i < DBW'(MIN_DATA)) begin
            data_n = LW'(MIN_DATA);
        end else if (data_bits_i > DBW'(MAX_DATA)) begin
            data_n = LW'(MAX_DATA);
        end else begin
            data_n = LW'(data_bits_i);
        end
        par_n      = parity_en_i ? LW'(1) : LW'(0);
        stop_n     = two_stop_i  ? LW'(2) : LW'(1);
        char_len_o = LW'(1) + data_n + par_n + stop_n;
    end

endmodule

// File: rtl/brk_tick_cnt.sv
module brk_tick_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic          tick_i,
    input  logic [CW-1:0] limit_i,
    output logic          done_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    // The terminal tick is the one that brings the count up to the limit.
    assign done_o = en_i && tick_i && (cnt_q == (limit_i - CW'(1)));

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (en_i && tick_i) begin
            cnt_d = done_o ? '0 : cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/brk_seq_fsm.sv
module brk_seq_fsm
    import brk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       pending_i,
    input  logic       cnt_done_i,
    output brk_state_e st_o,
    output logic       cnt_clr_o,
    output logic       cnt_en_o,
    output logic       gap_sel_o,
    output logic       len_latch_o,
    output logic       pause_o,
    output logic       ovr_en_o,
    output logic       ovr_val_o
);

    brk_fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.stop_seen = 1'b0;
                if (start_i) begin
                    r_d.st = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (stop_i) begin
                    r_d.stop_seen = 1'b1;
                end
                if (!pending_i) begin
                    r_d.st = ST_BRK_MIN;
                end
            end
            ST_BRK_MIN: begin
                if (stop_i) begin
                    r_d.stop_seen = 1'b1;
                end
                if (cnt_done_i) begin
                    r_d.st = (r_q.stop_seen || stop_i) ? ST_GAP : ST_BRK_HOLD;
                end
            end
            ST_BRK_HOLD: begin
                if (stop_i) begin
                    r_d.st = ST_GAP;
                end
            end
            ST_GAP: begin
                r_d.stop_seen = 1'b0;
                if (cnt_done_i) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: begin
                r_d.st        = ST_IDLE;
                r_d.stop_seen = 1'b0;
            end
        endcase
    end

    always_comb begin
        st_o        = r_q.st;
        cnt_clr_o   = (r_d.st != r_q.st);
        cnt_en_o    = (r_q.st == ST_BRK_MIN) || (r_q.st == ST_GAP);
        gap_sel_o   = (r_q.st == ST_GAP);
        len_latch_o = (r_q.st == ST_DRAIN) && !pending_i;
        ovr_en_o    = (r_q.st == ST_BRK_MIN) || (r_q.st == ST_BRK_HOLD)
                   || (r_q.st == ST_GAP);
        pause_o     = ovr_en_o;
        ovr_val_o   = (r_q.st == ST_GAP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st        <= ST_IDLE;
            r_q.stop_seen <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/brk_txd_mux.sv
module brk_txd_mux (
    input  logic ovr_en_i,
    input  logic ovr_val_i,
    input  logic ser_txd_i,
    output logic txd_o
);

    always_comb begin
        txd_o = ovr_en_i ? ovr_val_i : ser_txd_i;
    end

endmodule

// File: rtl/uart_brk_ctrl.sv
module uart_brk_ctrl
    import brk_pkg::*;
#(
    parameter int DBW      = 4,
    parameter int MIN_DATA = 5,
    parameter int MAX_DATA = 9,
    parameter int IDLE_GAP = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           brk_start_i,
    input  logic           brk_stop_i,
    input  logic           bit_tick_i,
    input  logic [DBW-1:0] data_bits_i,
    input  logic           parity_en_i,
    input  logic           two_stop_i,
    input  logic           hold_full_i,
    input  logic           shift_busy_i,
    input  logic           ser_txd_i,
    output logic           txd_o,
    output logic           tx_pause_o
);

    localparam int MAX_CHAR = MAX_DATA + 4;
    localparam int LW       = $clog2(MAX_CHAR + 1);
    localparam int MAX_CNT  = (MAX_CHAR > IDLE_GAP) ? MAX_CHAR : IDLE_GAP;
    localparam int CW       = $clog2(MAX_CNT + 1);

    brk_state_e    brk_st;
    logic          pending;
    logic          cnt_clr, cnt_en, cnt_done, gap_sel, len_latch;
    logic          ovr_en, ovr_val;
    logic [LW-1:0] char_len;
    logic [LW-1:0] len_d, len_q;
    logic [CW-1:0] limit;

    assign pending = hold_full_i | shift_busy_i;

    brk_char_len #(
        .DBW      (DBW),
        .MIN_DATA (MIN_DATA),
        .MAX_DATA (MAX_DATA),
        .LW       (LW)
    ) u_len (
        .data_bits_i (data_bits_i),
        .parity_en_i (parity_en_i),
        .two_stop_i  (two_stop_i),
        .char_len_o  (char_len)
    );

    // Character length is frozen as the line goes low.
    always_comb begin
        len_d = len_latch ? char_len : len_q;
        limit = gap_sel ? CW'(IDLE_GAP) : CW'(len_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= LW'(MIN_DATA + 2);
        end else begin
            len_q <= len_d;
        end
    end

    brk_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (brk_start_i),
        .stop_i      (brk_stop_i),
        .pending_i   (pending),
        .cnt_done_i  (cnt_done),
        .st_o        (brk_st),
        .cnt_clr_o   (cnt_clr),
        .cnt_en_o    (cnt_en),
        .gap_sel_o   (gap_sel),
        .len_latch_o (len_latch),
        .pause_o     (tx_pause_o),
        .ovr_en_o    (ovr_en),
        .ovr_val_o   (ovr_val)
    );

    brk_tick_cnt #(
        .CW (CW)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .en_i    (cnt_en),
        .tick_i  (bit_tick_i),
        .limit_i (limit),
        .done_o  (cnt_done)
    );

    brk_txd_mux u_mux (
        .ovr_en_i  (ovr_en),
        .ovr_val_i (ovr_val),
        .ser_txd_i (ser_txd_i),
        .txd_o     (txd_o)
    );

endmodule

// File: rtl/brk_ctrl_checker.sv
module brk_ctrl_checker
    import brk_pkg::*;
#(
    parameter int MIN_CHAR = 7,
    parameter int IDLE_GAP = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       brk_start_i,
    input logic       brk_stop_i,
    input logic       bit_tick_i,
    input logic       hold_full_i,
    input logic       shift_busy_i,
    input logic       txd_o,
    input logic       tx_pause_o,
    input brk_state_e brk_st
);

    localparam int TW = $clog2(((MIN_CHAR > IDLE_GAP) ? MIN_CHAR : IDLE_GAP) + 2) + 1;

    logic [TW-1:0] brk_ticks, gap_ticks;
    logic          in_brk;

    assign in_brk = (brk_st == ST_BRK_MIN) || (brk_st == ST_BRK_HOLD);

    // Independent tick tallies per phase, saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_ticks <= '0;
            gap_ticks <= '0;
        end else begin
            if (!in_brk) begin
                brk_ticks <= '0;
            end else if (bit_tick_i && (brk_ticks != '1)) begin
                brk_ticks <= brk_ticks + TW'(1);
            end
            if (brk_st != ST_GAP) begin
                gap_ticks <= '0;
            end else if (bit_tick_i && (gap_ticks != '1)) begin
                gap_ticks <= gap_ticks + TW'(1);
            end
        end
    end

    a_r1_wait_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_st == ST_DRAIN && (hold_full_i || shift_busy_i)) |=> (brk_st == ST_DRAIN));

    a_r2_line_low: assert property (@(posedge clk) disable iff (!rst_n)
        in_brk |-> (txd_o == 1'b0 && tx_pause_o == 1'b1));

    a_r3_hold_until_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_st == ST_BRK_HOLD && !brk_stop_i) |=> (brk_st == ST_BRK_HOLD));

    a_r3_min_length: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_st == ST_GAP && $past(brk_st) != ST_GAP) |-> (brk_ticks >= TW'(MIN_CHAR)));

    a_r5_gap_high: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_st == ST_GAP) |-> (txd_o == 1'b1 && tx_pause_o == 1'b1));

    a_r5_gap_length: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_st == ST_IDLE && $past(brk_st) == ST_GAP) |-> (gap_ticks == TW'(IDLE_GAP)));

    a_r6_stop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_st == ST_IDLE && brk_stop_i && !brk_start_i) |=> (brk_st == ST_IDLE));

    a_r2_pause_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_pause_o) |-> (brk_st == ST_BRK_MIN));

endmodule

bind uart_brk_ctrl brk_ctrl_checker #(
    .MIN_CHAR (MIN_DATA + 2),
    .IDLE_GAP (IDLE_GAP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .brk_start_i  (brk_start_i),
    .brk_stop_i   (brk_stop_i),
    .bit_tick_i   (bit_tick_i),
    .hold_full_i  (hold_full_i),
    .shift_busy_i (shift_busy_i),
    .txd_o        (txd_o),
    .tx_pause_o   (tx_pause_o),
    .brk_st       (brk_st)
);

// File: tb/sim_uart_brk_ctrl.sv
`timescale 1ns/1ps
module sim_uart_brk_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       brk_start_i = 1'b0;
    logic       brk_stop_i = 1'b0;
    logic       bit_tick_i = 1'b0;
    logic [3:0] data_bits_i = 4'd5;
    logic       parity_en_i = 1'b0;
    logic       two_stop_i = 1'b0;
    logic       hold_full_i = 1'b0;
    logic       shift_busy_i = 1'b0;
    logic       ser_txd_i = 1'b1;
    logic       txd_o;
    logic       tx_pause_o;

    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    uart_brk_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .brk_start_i  (brk_start_i),
        .brk_stop_i   (brk_stop_i),
        .bit_tick_i   (bit_tick_i),
        .data_bits_i  (data_bits_i),
        .parity_en_i  (parity_en_i),
        .two_stop_i   (two_stop_i),
        .hold_full_i  (hold_full_i),
        .shift_busy_i (shift_busy_i),
        .ser_txd_i    (ser_txd_i),
        .txd_o        (txd_o),
        .tx_pause_o   (tx_pause_o)
    );

    // {repeat, start, stop, tick, hold_full, shift_busy, exp_txd, exp_pause}
    // Frame: 5 data bits, no parity, one stop -> 7 ticks per character.
    localparam logic [10:0] VEC [19] = '{
        {4'd1,  7'b0000010},  // idle
        {4'd1,  7'b0100010},  // R6 stop while idle
        {4'd1,  7'b1001110},  // R1 start, both busy -> drain
        {4'd2,  7'b0011110},  // R7 ticks while draining
        {4'd1,  7'b0000110},  // R1 shift still busy
        {4'd1,  7'b0000001},  // R2 drained -> line low
        {4'd1,  7'b0110001},  // R3 early stop, tick 1
        {4'd1,  7'b1010001},  // R6 repeated start, tick 2
        {4'd4,  7'b0010001},  // ticks 3..6
        {4'd1,  7'b0010011},  // R3 tick 7 -> gap
        {4'd11, 7'b0010011},  // R5 gap ticks 1..11
        {4'd1,  7'b0010010},  // R5 tick 12 -> idle
        {4'd1,  7'b1000010},  // start, nothing pending
        {4'd1,  7'b0000001},  // line low
        {4'd7,  7'b0010001},  // minimum length, no stop yet
        {4'd3,  7'b0010001},  // R7 ticks while waiting for stop
        {4'd1,  7'b0100011},  // R3 stop -> gap
        {4'd11, 7'b0010011},  // gap
        {4'd1,  7'b0010010}   // back to idle
    };

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: {txd,pause}=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle of inputs, let one edge pass, sample at the falling edge.
    task automatic cyc(input logic st, input logic sp, input logic tk);
        brk_start_i = st;
        brk_stop_i  = sp;
        bit_tick_i  = tk;
        @(negedge clk);
        brk_start_i = 1'b0;
        brk_stop_i  = 1'b0;
        bit_tick_i  = 1'b0;
    endtask

    // Full break with early stop; optional frame change after the line goes low.
    task automatic run_break(input int exp_len, input bit reframe, input string req);
        cyc(1'b1, 1'b0, 1'b0);
        chk("R1 drain", {txd_o, tx_pause_o}, 2'b10);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R2 break start", {txd_o, tx_pause_o}, 2'b01);
        if (reframe) begin
            data_bits_i = 4'd9;
            parity_en_i = 1'b1;
            two_stop_i  = 1'b1;
        end
        cyc(1'b0, 1'b1, 1'b1);
        chk(req, {txd_o, tx_pause_o}, 2'b01);
        for (int i = 2; i < exp_len; i++) begin
            cyc(1'b0, 1'b0, 1'b1);
            chk(req, {txd_o, tx_pause_o}, 2'b01);
        end
        cyc(1'b0, 1'b0, 1'b1);
        chk(req, {txd_o, tx_pause_o}, 2'b11);
        ser_txd_i = 1'b0;
        for (int i = 1; i < 12; i++) begin
            cyc(1'b0, 1'b0, 1'b1);
            chk("R5 gap forced high", {txd_o, tx_pause_o}, 2'b11);
        end
        cyc(1'b0, 1'b0, 1'b1);
        chk("R5 gap end pass-through", {txd_o, tx_pause_o}, 2'b00);
        ser_txd_i = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        // R8 reset state
        @(negedge clk);
        chk("R8 in reset", {txd_o, tx_pause_o}, 2'b10);
        ser_txd_i = 1'b0;
        #0.1;
        chk("R8 reset pass-through", {txd_o, tx_pause_o}, 2'b00);
        ser_txd_i = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 after reset", {txd_o, tx_pause_o}, 2'b10);

        // Vector table: R1 R2 R3 R5 R6 R7
        for (int v = 0; v < 19; v++) begin
            for (int k = 0; k < int'(VEC[v][10:7]); k++) begin
                hold_full_i  = VEC[v][3];
                shift_busy_i = VEC[v][2];
                cyc(VEC[v][6], VEC[v][5], VEC[v][4]);
                chk($sformatf("R1/R2/R3/R5/R6/R7 vector %0d", v),
                    {txd_o, tx_pause_o}, VEC[v][1:0]);
            end
        end
        hold_full_i  = 1'b0;
        shift_busy_i = 1'b0;

        // R4 longest frame: 9 data, parity, two stop -> 13 ticks
        data_bits_i = 4'd9; parity_en_i = 1'b1; two_stop_i = 1'b1;
        run_break(13, 1'b0, "R4 length 13");

        // R4 clamp: 2 data bits treated as 5 -> 7 ticks
        data_bits_i = 4'd2; parity_en_i = 1'b0; two_stop_i = 1'b0;
        run_break(7, 1'b0, "R4 clamp low");

        // R4 clamp high: 15 data bits treated as 9, parity off, one stop -> 11
        data_bits_i = 4'd15;
        run_break(11, 1'b0, "R4 clamp high");

        // R4 length captured at break start; reframe mid-break ignored
        data_bits_i = 4'd6; parity_en_i = 1'b0; two_stop_i = 1'b0;
        run_break(8, 1'b1, "R4 latched length");

        // R3 stop during drain is remembered
        data_bits_i = 4'd5; parity_en_i = 1'b0; two_stop_i = 1'b0;
        hold_full_i = 1'b1;
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0);
        chk("R3 stop in drain", {txd_o, tx_pause_o}, 2'b10);
        hold_full_i = 1'b0;
        cyc(1'b0, 1'b0, 1'b0);
        chk("R3 low after drain", {txd_o, tx_pause_o}, 2'b01);
        for (int i = 1; i < 7; i++) begin
            cyc(1'b0, 1'b0, 1'b1);
        end
        chk("R3 still low at tick 6", {txd_o, tx_pause_o}, 2'b01);
        cyc(1'b0, 1'b0, 1'b1);
        chk("R3 stop in drain ends at tick 7", {txd_o, tx_pause_o}, 2'b11);
        for (int i = 0; i < 12; i++) begin
            cyc(1'b0, 1'b0, 1'b1);
        end
        chk("R5 idle again", {txd_o, tx_pause_o}, 2'b10);

        // R8 reset in the middle of a held break
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 9; i++) begin
            cyc(1'b0, 1'b0, 1'b1);
        end
        chk("R3 held low without stop", {txd_o, tx_pause_o}, 2'b01);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 reset during break", {txd_o, tx_pause_o}, 2'b10);
        rst_n = 1'b1;
        cyc(1'b0, 1'b1, 1'b1);
        chk("R6 stop after reset ignored", {txd_o, tx_pause_o}, 2'b10);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule